// File: doc/BRIEF.md
# Front-Panel Run Control and Bus Borrowing Unit

This unit connects an operator console of switches and lamps to the bus of an 8-bit processor with a 16-bit address. The operator can start the processor, stop it, or step it one instruction at a time. A breakpoint address loaded from the console halts execution as soon as the processor starts a bus cycle at that address, provided the breakpoint switch is on. The stop is sticky: only the start control releases it.

The console can also read and write single memory bytes. This works while the processor runs. A console request is taken only when the processor opens a new bus cycle, or while the processor is halted and idle. The unit then stretches that processor cycle with wait states, drives the memory strobes for a fixed two-clock access, and hands the bus back. The lamps show the address and data of the most recent bus transfer, whether it came from the processor or from the console, and a lamp that is lit while the processor runs freely.

Top module: `fpanel_ctrl`

## Requirements
- R1: Reset leaves the unit stopped: `cpu_halt` high, `led_run` low, `cpu_wait`, `mem_en`, `mem_we` and `pnl_ack` low, and `led_addr`, `led_data`, `pnl_rdata` and the breakpoint register all zero.
- R2: A `sw_start` pulse puts the unit in free run (`cpu_halt` low from the next clock). A `sw_stop` pulse stops it (`cpu_halt` high from the next clock). Stop takes priority over a simultaneous start.
- R3: A `sw_step` pulse while stopped drops `cpu_halt` until one cycle with `cpu_fetch` high completes. `cpu_halt` is high again from the clock after that completion, so exactly one fetch cycle completes for each step.
- R4: While `sw_bp_en` is high, a processor cycle that starts with `cpu_addr` equal to the breakpoint register stops the unit from the next clock. The unit stays stopped until a `sw_start` or `sw_step` pulse, and the hit takes priority over a simultaneous start.
- R5: While `sw_bp_en` is low, a matching address has no effect on run state.
- R6: A `sw_bp_load` pulse copies `pnl_addr` into the breakpoint register.
- R7: A held `pnl_req` is granted only on a clock where a processor cycle starts (`cpu_req` high and no cycle open), or while `cpu_halt` is high and `cpu_req` is low. A request made while the processor runs but is idle waits for its next cycle.
- R8: `cpu_wait` is high combinationally on the grant clock and on both access clocks that follow. A processor cycle completes on a clock where `cpu_req` is high and `cpu_wait` is low.
- R9: After a grant, `mem_en` is high for exactly two clocks with `mem_addr`/`mem_wdata` equal to the captured `pnl_addr`/`pnl_wdata`. `mem_we` is high on those clocks only when `pnl_we` was high at grant.
- R10: `pnl_ack` pulses for one clock right after the second access clock. For a read, `pnl_rdata` then holds the `mem_rdata` value sampled on the second access clock. A write leaves `pnl_rdata` unchanged.
- R11: `led_addr`/`led_data` take the address and data of each completed processor cycle, and at the end of a console access they take its address and its written or read byte.
- R12: `led_run` is high exactly while the unit is in free run (not stopped, not stepping).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | Processor address of current cycle |
| cpu_data | input | 8 | Processor data of current cycle |
| cpu_req | input | 1 | Processor bus cycle in progress |
| cpu_fetch | input | 1 | Current cycle is an instruction fetch |
| cpu_wait | output | 1 | Wait request to the processor |
| cpu_halt | output | 1 | Halt request: no new cycle may start |
| sw_start | input | 1 | Start pulse |
| sw_stop | input | 1 | Stop pulse |
| sw_step | input | 1 | Single-step pulse |
| sw_bp_en | input | 1 | Breakpoint enable switch |
| sw_bp_load | input | 1 | Load breakpoint from `pnl_addr` |
| pnl_addr | input | 16 | Console address switches |
| pnl_wdata | input | 8 | Console data switches |
| pnl_we | input | 1 | Console access is a write |
| pnl_req | input | 1 | Console access request, held until ack |
| pnl_ack | output | 1 | Console access finished |
| pnl_rdata | output | 8 | Byte returned by the last console read |
| mem_addr | output | 16 | Console access address to memory |
| mem_wdata | output | 8 | Console write data to memory |
| mem_we | output | 1 | Console write strobe |
| mem_en | output | 1 | Console access strobe |
| mem_rdata | input | 8 | Memory read data |
| led_addr | output | 16 | Address lamps |
| led_data | output | 8 | Data lamps |
| led_run | output | 1 | Run lamp |

## Verification
The assertions assume that `sw_start`, `sw_stop` and `sw_step` are single-clock pulses. They also assume that the processor opens no new cycle while `cpu_halt` is high, keeps `cpu_req`, address and data steady until the cycle completes, and that `pnl_req` and its fields stay steady until `pnl_ack` and drop right after it. The bench processor model checks the halt and wait outputs after every edge before it starts a cycle. It holds its cycle open until it sees `cpu_wait` low. The console task drives only full, acknowledged requests, and the control switches are driven only through one-clock pulse tasks.

// File: rtl/fp_pkg.sv
`timescale 1ns/1ps
package fp_pkg;

  typedef enum logic [1:0] {
    FP_STOP = 2'd0,
    FP_RUN  = 2'd1,
    FP_STEP = 2'd2
  } fp_run_e;

  // breakpoint comparator, widths padded to 32 bits by the caller
  function automatic logic fp_addr_hit(input logic en, input logic [31:0] a,
                                       input logic [31:0] bp);
    return en && (a == bp);
  endfunction

  // run-state priority: stop/hit, then start, then step entry, then step end
  function automatic fp_run_e fp_next_run(input fp_run_e cur, input logic hit,
                                          input logic stop, input logic start,
                                          input logic step, input logic fetch_done);
    fp_run_e nxt;
    nxt = cur;
    if (hit || stop)                        nxt = FP_STOP;
    else if (start)                         nxt = FP_RUN;
    else if (cur == FP_STOP && step)        nxt = FP_STEP;
    else if (cur == FP_STEP && fetch_done)  nxt = FP_STOP;
    return nxt;
  endfunction

endpackage

// File: rtl/fp_run_ctrl.sv
`timescale 1ns/1ps
module fp_run_ctrl
  import fp_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sw_start,
  input  logic          sw_stop,
  input  logic          sw_step,
  input  logic          sw_bp_en,
  input  logic          sw_bp_load,
  input  logic [AW-1:0] bp_value,
  input  logic          cyc_start,
  input  logic [AW-1:0] cyc_addr,
  input  logic          fetch_done,
  output logic          halt,
  output logic          running,
  output logic          bp_hit
);

  fp_run_e       state_q;
  fp_run_e       state_d;
  logic [AW-1:0] bp_q;

  assign bp_hit  = cyc_start && fp_addr_hit(sw_bp_en, 32'(cyc_addr), 32'(bp_q));
  assign state_d = fp_next_run(state_q, bp_hit, sw_stop, sw_start, sw_step, fetch_done);
  assign halt    = (state_q == FP_STOP);
  assign running = (state_q == FP_RUN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= FP_STOP;
      bp_q    <= '0;
    end else begin
      state_q <= state_d;
      if (sw_bp_load) bp_q <= bp_value;
    end
  end

endmodule

// File: rtl/fp_bus_borrow.sv
`timescale 1ns/1ps
module fp_bus_borrow #(
  parameter int AW      = 16,
  parameter int DW      = 8,
  parameter int ACC_CYC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_req,
  input  logic          halted,
  input  logic          pnl_req,
  input  logic          pnl_we,
  input  logic [AW-1:0] pnl_addr,
  input  logic [DW-1:0] pnl_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          cpu_wait,
  output logic          cyc_start,
  output logic          cyc_done,
  output logic          grant,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          acc_done,
  output logic [DW-1:0] acc_data,
  output logic          pnl_ack,
  output logic [DW-1:0] pnl_rdata
);

  localparam int CW = $clog2(ACC_CYC + 1);

  logic          open_q;
  logic [CW-1:0] left_q;
  logic          we_q;
  logic          ack_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic [DW-1:0] rdata_q;
  logic          idle_slot;

  assign cyc_start = cpu_req && !open_q;
  assign idle_slot = halted && !cpu_req;
  assign grant     = pnl_req && (left_q == '0) && !ack_q && (cyc_start || idle_slot);
  assign cpu_wait  = grant || (left_q != '0);
  assign cyc_done  = cpu_req && !cpu_wait;
  assign acc_done  = (left_q == CW'(1));
  assign acc_data  = we_q ? wdata_q : mem_rdata;

  assign mem_en    = (left_q != '0);
  assign mem_we    = mem_en && we_q;
  assign mem_addr  = addr_q;
  assign mem_wdata = wdata_q;
  assign pnl_ack   = ack_q;
  assign pnl_rdata = rdata_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q  <= 1'b0;
      left_q  <= '0;
      we_q    <= 1'b0;
      ack_q   <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      open_q <= cpu_req && cpu_wait;
      ack_q  <= acc_done;
      if (acc_done && !we_q) rdata_q <= mem_rdata;
      if (grant) begin
        left_q  <= CW'(ACC_CYC);
        we_q    <= pnl_we;
        addr_q  <= pnl_addr;
        wdata_q <= pnl_wdata;
      end else if (left_q != '0) begin
        left_q <= left_q - CW'(1);
      end
    end
  end

endmodule

// File: rtl/fp_led_latch.sv
`timescale 1ns/1ps
module fp_led_latch #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cyc_done,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_data,
  input  logic          acc_done,
  input  logic [AW-1:0] acc_addr,
  input  logic [DW-1:0] acc_data,
  output logic [AW-1:0] led_addr,
  output logic [DW-1:0] led_data
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      led_addr <= '0;
      led_data <= '0;
    end else if (acc_done) begin
      led_addr <= acc_addr;
      led_data <= acc_data;
    end else if (cyc_done) begin
      led_addr <= cpu_addr;
      led_data <= cpu_data;
    end
  end

endmodule

// File: rtl/fpanel_ctrl.sv
`timescale 1ns/1ps
module fpanel_ctrl #(
  parameter int AW      = 16,
  parameter int DW      = 8,
  parameter int ACC_CYC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_data,
  input  logic          cpu_req,
  input  logic          cpu_fetch,
  output logic          cpu_wait,
  output logic          cpu_halt,
  input  logic          sw_start,
  input  logic          sw_stop,
  input  logic          sw_step,
  input  logic          sw_bp_en,
  input  logic          sw_bp_load,
  input  logic [AW-1:0] pnl_addr,
  input  logic [DW-1:0] pnl_wdata,
  input  logic          pnl_we,
  input  logic          pnl_req,
  output logic          pnl_ack,
  output logic [DW-1:0] pnl_rdata,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we,
  output logic          mem_en,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] led_addr,
  output logic [DW-1:0] led_data,
  output logic          led_run
);

  // named internal events, also used by the bound checker
  logic          w_cyc_start;
  logic          w_cyc_done;
  logic          w_grant;
  logic          w_bp_hit;
  logic          w_acc_done;
  logic          w_fetch_done;
  logic [DW-1:0] w_acc_data;

  assign w_fetch_done = w_cyc_done && cpu_fetch;

  fp_run_ctrl #(.AW(AW)) u_run (
    .clk        (clk),
    .rst_n      (rst_n),
    .sw_start   (sw_start),
    .sw_stop    (sw_stop),
    .sw_step    (sw_step),
    .sw_bp_en   (sw_bp_en),
    .sw_bp_load (sw_bp_load),
    .bp_value   (pnl_addr),
    .cyc_start  (w_cyc_start),
    .cyc_addr   (cpu_addr),
    .fetch_done (w_fetch_done),
    .halt       (cpu_halt),
    .running    (led_run),
    .bp_hit     (w_bp_hit)
  );

  fp_bus_borrow #(.AW(AW), .DW(DW), .ACC_CYC(ACC_CYC)) u_borrow (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_req   (cpu_req),
    .halted    (cpu_halt),
    .pnl_req   (pnl_req),
    .pnl_we    (pnl_we),
    .pnl_addr  (pnl_addr),
    .pnl_wdata (pnl_wdata),
    .mem_rdata (mem_rdata),
    .cpu_wait  (cpu_wait),
    .cyc_start (w_cyc_start),
    .cyc_done  (w_cyc_done),
    .grant     (w_grant),
    .mem_en    (mem_en),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .acc_done  (w_acc_done),
    .acc_data  (w_acc_data),
    .pnl_ack   (pnl_ack),
    .pnl_rdata (pnl_rdata)
  );

  fp_led_latch #(.AW(AW), .DW(DW)) u_led (
    .clk      (clk),
    .rst_n    (rst_n),
    .cyc_done (w_cyc_done),
    .cpu_addr (cpu_addr),
    .cpu_data (cpu_data),
    .acc_done (w_acc_done),
    .acc_addr (mem_addr),
    .acc_data (w_acc_data),
    .led_addr (led_addr),
    .led_data (led_data)
  );

endmodule

// File: rtl/fp_checker.sv
`timescale 1ns/1ps
module fp_checker (
  input logic clk,
  input logic rst_n,
  input logic cpu_req,
  input logic cpu_wait,
  input logic cpu_halt,
  input logic mem_en,
  input logic mem_we,
  input logic pnl_ack,
  input logic led_run,
  input logic sw_start,
  input logic sw_step,
  input logic grant,
  input logic cyc_start,
  input logic bp_hit
);

  assert_strobe_second_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_en) |=> mem_en);

  assert_strobe_ends_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && $past(mem_en)) |=> !mem_en);

  assert_write_inside_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_en);

  assert_wait_covers_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> cpu_wait);

  assert_grant_slot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> (cyc_start || (cpu_halt && !cpu_req)));

  assert_ack_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_en) |-> pnl_ack);

  assert_ack_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pnl_ack |-> !mem_en);

  assert_bp_stops_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bp_hit |=> cpu_halt);

  assert_stop_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_halt && !sw_start && !sw_step) |=> cpu_halt);

  assert_run_lamp_R12: assert property (@(posedge clk) disable iff (!rst_n)
    led_run |-> !cpu_halt);

endmodule

bind fpanel_ctrl fp_checker u_fp_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .cpu_req   (cpu_req),
  .cpu_wait  (cpu_wait),
  .cpu_halt  (cpu_halt),
  .mem_en    (mem_en),
  .mem_we    (mem_we),
  .pnl_ack   (pnl_ack),
  .led_run   (led_run),
  .sw_start  (sw_start),
  .sw_step   (sw_step),
  .grant     (w_grant),
  .cyc_start (w_cyc_start),
  .bp_hit    (w_bp_hit)
);

// File: tb/test_fpanel_ctrl.sv
`timescale 1ns/1ps
module test_fpanel_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_data = '0;
  logic        cpu_req = 1'b0, cpu_fetch = 1'b0;
  logic        cpu_wait, cpu_halt;
  logic        sw_start = 0, sw_stop = 0, sw_step = 0, sw_bp_en = 0, sw_bp_load = 0;
  logic [15:0] pnl_addr = '0;
  logic [7:0]  pnl_wdata = '0;
  logic        pnl_we = 0, pnl_req = 0;
  logic        pnl_ack;
  logic [7:0]  pnl_rdata;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        mem_we, mem_en;
  logic [7:0]  mem_rdata;
  logic [15:0] led_addr;
  logic [7:0]  led_data;
  logic        led_run;

  always #2.5 clk = ~clk;

  fpanel_ctrl i_fpanel_ctrl (.*);

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // memory seen through the strobes
  logic [7:0] bmem [256];
  assign mem_rdata = bmem[mem_addr[7:0]];
  always @(posedge clk) if (mem_we) bmem[mem_addr[7:0]] <= mem_wdata;

  // behavioural reference, updated on each edge from the driven inputs
  int         m_state;           // 0 stopped, 1 running, 2 stepping
  bit         m_open, m_ack, m_pwe;
  int         m_left;
  logic [7:0] m_rdata, m_ld, m_pd;
  logic [15:0] m_bp, m_la, m_pa;
  logic [7:0] m_mem [256];

  function automatic bit exp_wait();
    bit cs, gr;
    cs = cpu_req && !m_open;
    gr = pnl_req && m_left == 0 && !m_ack && (cs || (m_state == 0 && !cpu_req));
    return gr || m_left > 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_state = 0; m_open = 0; m_left = 0; m_ack = 0; m_rdata = 0;
      m_bp = 0; m_la = 0; m_ld = 0; m_pa = 0; m_pd = 0; m_pwe = 0;
    end else begin
      bit cs, gr, w, comp, hit;
      int ns;
      cs   = cpu_req && !m_open;
      gr   = pnl_req && m_left == 0 && !m_ack && (cs || (m_state == 0 && !cpu_req));
      w    = gr || m_left > 0;
      comp = cpu_req && !w;
      hit  = cs && sw_bp_en && cpu_addr == m_bp;
      ns = m_state;
      if (hit || sw_stop) ns = 0;
      else if (sw_start) ns = 1;
      else if (m_state == 0 && sw_step) ns = 2;
      else if (m_state == 2 && comp && cpu_fetch) ns = 0;
      if (sw_bp_load) m_bp = pnl_addr;
      m_ack = (m_left == 1);
      if (m_left == 1) begin
        if (m_pwe) begin m_mem[m_pa[7:0]] = m_pd; m_ld = m_pd; end
        else begin m_rdata = m_mem[m_pa[7:0]]; m_ld = m_rdata; end
        m_la = m_pa;
      end
      if (comp) begin m_la = cpu_addr; m_ld = cpu_data; end
      m_open = cpu_req && w;
      if (gr) begin m_left = 2; m_pa = pnl_addr; m_pd = pnl_wdata; m_pwe = pnl_we; end
      else if (m_left > 0) m_left--;
      m_state = ns;
    end
  end

  // clock-by-clock comparison away from the active edge
  bit cmp_on = 0;
  bit wait_seen = 0;
  always @(negedge clk) begin
    wait_seen = cpu_wait;
    if (rst_n && cmp_on) begin
      chk(cpu_wait === exp_wait(), "R8", "cpu_wait", cpu_wait, exp_wait());
      chk(cpu_halt === (m_state == 0), "R2", "cpu_halt", cpu_halt, m_state == 0);
      chk(led_run === (m_state == 1), "R12", "led_run", led_run, m_state == 1);
      chk(mem_en === (m_left > 0), "R9", "mem_en", mem_en, m_left > 0);
      chk(mem_we === (m_left > 0 && m_pwe), "R9", "mem_we", mem_we, m_left > 0 && m_pwe);
      if (m_left > 0) begin
        chk(mem_addr === m_pa, "R9", "mem_addr", mem_addr, m_pa);
        if (m_pwe) chk(mem_wdata === m_pd, "R9", "mem_wdata", mem_wdata, m_pd);
      end
      chk(pnl_ack === m_ack, "R10", "pnl_ack", pnl_ack, m_ack);
      chk(pnl_rdata === m_rdata, "R10", "pnl_rdata", pnl_rdata, m_rdata);
      chk(led_addr === m_la, "R11", "led_addr", led_addr, m_la);
      chk(led_data === m_ld, "R11", "led_data", led_data, m_ld);
    end
  end

  // processor model: obeys halt, holds each cycle until wait is low
  int cpu_n = 0;
  bit cpu_go = 0, cpu_idle = 0;
  int fetch_cnt = 0;
  bit cpu_fin;
  always @(posedge clk) begin
    #1;
    if (!rst_n) begin
      cpu_req = 0;
    end else begin
      cpu_fin = cpu_req && !wait_seen;
      if (cpu_fin) begin
        if (cpu_fetch) fetch_cnt++;
        cpu_n++;
      end
      if (!cpu_req || cpu_fin) begin
        if (cpu_go && !cpu_idle && !cpu_halt) begin
          cpu_req   = 1;
          cpu_addr  = 16'h0100 + cpu_n[15:0];
          cpu_fetch = (cpu_n % 3 == 0);
          cpu_data  = 8'(cpu_n * 7 + 1);
        end else begin
          cpu_req = 0;
        end
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulse_start(); tick(1); sw_start = 1; tick(1); sw_start = 0; endtask
  task automatic pulse_stop();  tick(1); sw_stop  = 1; tick(1); sw_stop  = 0; endtask
  task automatic pulse_step();  tick(1); sw_step  = 1; tick(1); sw_step  = 0; endtask

  task automatic panel(input bit we, input logic [15:0] a, input logic [7:0] d,
                       output logic [7:0] rd, input string rq);
    bit got = 0;
    tick(1);
    pnl_we = we; pnl_addr = a; pnl_wdata = d; pnl_req = 1;
    for (int i = 0; i < 200 && !got; i++) begin
      @(negedge clk);
      if (pnl_ack) got = 1;
    end
    rd = pnl_rdata;
    chk(got, rq, "console ack seen", got, 1);
    tick(1);
    pnl_req = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0]  rd;
    logic [15:0] target;
    int          tn, cnt;
    for (int i = 0; i < 256; i++) begin
      bmem[i]  = 8'(i) ^ 8'hA5;
      m_mem[i] = 8'(i) ^ 8'hA5;
    end
    tick(4);
    @(negedge clk);
    // R1 reset state
    chk(cpu_halt === 1, "R1", "halt at reset", cpu_halt, 1);
    chk(led_run === 0, "R1", "run lamp at reset", led_run, 0);
    chk(cpu_wait === 0 && mem_en === 0 && mem_we === 0 && pnl_ack === 0,
        "R1", "strobes at reset", {cpu_wait, mem_en, mem_we, pnl_ack}, 0);
    chk(led_addr === 0 && led_data === 0 && pnl_rdata === 0, "R1", "lamps at reset",
        led_addr, 0);
    tick(1);
    rst_n = 1; cmp_on = 1;

    // R6 / R5: load breakpoint inside the coming stream, but disabled
    pnl_addr = 16'h0105; sw_bp_load = 1; tick(1); sw_bp_load = 0;
    cpu_go = 1;
    pulse_start();
    cnt = 0;
    for (int i = 0; i < 30; i++) begin @(negedge clk); if (cpu_halt) cnt++; end
    chk(cnt == 0, "R5", "halted clocks with enable off", cnt, 0);
    chk(cpu_n > 8, "R2", "processor progressed in run", cpu_n, 9);

    // console write and read-back while running
    panel(1, 16'h0040, 8'h3C, rd, "R9");
    panel(0, 16'h0040, 8'h00, rd, "R10");
    chk(rd === 8'h3C, "R10", "read-back of written byte", rd, 8'h3C);
    panel(0, 16'h0017, 8'h00, rd, "R10");
    chk(rd === (8'h17 ^ 8'hA5), "R10", "read of untouched byte", rd, 8'h17 ^ 8'hA5);

    // R7: request while running but idle is held off
    cpu_idle = 1; tick(4);
    pnl_we = 1; pnl_addr = 16'h0081; pnl_wdata = 8'h5A; pnl_req = 1;
    cnt = 0;
    for (int i = 0; i < 10; i++) begin @(negedge clk); if (mem_en) cnt++; end
    chk(cnt == 0, "R7", "strobe clocks while processor idle", cnt, 0);
    tick(1); cpu_idle = 0;
    cnt = 0;
    for (int i = 0; i < 50 && !pnl_ack; i++) @(negedge clk);
    chk(pnl_ack === 1, "R7", "granted at next cycle start", pnl_ack, 1);
    tick(1); pnl_req = 0;

    // R4 / R6: enabled breakpoint ahead of the processor
    tick(1);
    tn = cpu_n + 12;
    target = 16'h0100 + tn[15:0];
    pnl_addr = target; sw_bp_load = 1; sw_bp_en = 1;
    tick(1); sw_bp_load = 0;
    for (int i = 0; i < 100 && !cpu_halt; i++) @(negedge clk);
    chk(cpu_halt === 1, "R4", "stopped at breakpoint", cpu_halt, 1);
    tick(3); @(negedge clk);
    chk(led_addr === target, "R6", "stop address equals loaded value", led_addr, target);
    chk(led_data === 8'(tn * 7 + 1), "R11", "data lamps at stop", led_data, 8'(tn * 7 + 1));
    cnt = 0;
    for (int i = 0; i < 10; i++) begin @(negedge clk); if (!cpu_halt) cnt++; end
    chk(cnt == 0, "R4", "stop is sticky", cnt, 0);
    sw_bp_en = 0;

    // R7: console access while halted and idle
    panel(0, 16'h0081, 8'h00, rd, "R7");
    chk(rd === 8'h5A, "R7", "read while halted", rd, 8'h5A);

    // R3: single steps
    for (int k = 0; k < 4; k++) begin
      tick(1); fetch_cnt = 0;
      pulse_step();
      for (int i = 0; i < 50 && !cpu_halt; i++) @(negedge clk);
      tick(6);
      chk(fetch_cnt == 1, "R3", "fetches completed per step", fetch_cnt, 1);
    end

    // R2 / R12: run, then stop
    pulse_start(); tick(10); @(negedge clk);
    chk(led_run === 1 && cpu_halt === 0, "R12", "run lamp in free run", led_run, 1);
    panel(1, 16'h00FF, 8'hC3, rd, "R9");
    pulse_stop(); @(negedge clk);
    chk(cpu_halt === 1, "R2", "halt after stop", cpu_halt, 1);
    chk(led_run === 0, "R12", "run lamp after stop", led_run, 0);
    panel(0, 16'h00FF, 8'h00, rd, "R10");
    chk(rd === 8'hC3, "R10", "read-back while stopped", rd, 8'hC3);

    tick(3);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule